// File: doc/BRIEF.md
# Banked Interrupt Distributor Control Register

This block holds the global control word of an interrupt distributor and a read-only configuration word that describes it. Each access carries a security attribute. The control word shows different writable bits to secure and non-secure writers, and a different read view to non-secure readers. Routing by affinity is always on, so both routing-enable bits read as one, and writes to them have no effect. A sticky security-disable bit switches the register to a single-security layout. Setting it also clears the bits that only make sense when two security states exist.

Software writes a 32-bit word with `wr_en` for one clock. Both registers are read combinationally through `rd_sel` and `rd_secure`. A write becomes visible on reads in the cycle after its clock edge. The group-enable outputs go to the interrupt delivery logic. That logic sits outside this block.

Top module: `banked_dist_ctrl`

## Requirements
- R1: After reset, a secure read of the control word (`rd_sel`=0) returns 0x00000030. That value has both routing bits (bit 4 secure, bit 5 non-secure) set and every other bit clear.
- R2: Bit 4 of the control word always reads 1. Bit 5 reads 1 until security is disabled. No write value changes either bit, apart from the clearing of bit 5 described in R6.
- R3: While security is enabled (bit 6 = 0), a secure write sets bits 0 (group-0 enable), 1 (non-secure group-1 enable) and 2 (secure group-1 enable) from the written data. All other written bits except bit 6 are ignored.
- R4: While security is enabled, a non-secure write changes only bit 1. Bits 0, 2 and 6 keep their values.
- R5: While security is enabled, a non-secure read of the control word returns bit 4 as 1, bit 1 as the current non-secure group-1 enable, and zero in every other bit. Bit 31 reads 0 in every view, because writes complete in one cycle.
- R6: A secure write with bit 6 = 1 while security is enabled sets the disable bit (bit 6). In the same update it clears bit 2 and bit 5, whatever the data in bit 2.
- R7: Once the disable bit is set, any write, secure or not, changes only bits 0 and 1. The disable bit stays at 1, and secure and non-secure reads return the same full view.
- R8: The configuration word (`rd_sel`=1) reads {bit 25=1, bit 24=1, bits 23:19=0xF, bit 10=SEC_SUPPORTED, bits 4:0=(NUM_IRQ-32)/32-1}, with all other bits 0. Writes with `wr_sel`=1 change nothing. For the defaults (NUM_IRQ=256, SEC_SUPPORTED=1) the word is 0x03780406.
- R9: Only a reset returns the disable bit to 0. After a reset the register reads the R1 value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control word, 1 configuration word |
| wr_secure | input | 1 | Write is a secure access |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 configuration word |
| rd_secure | input | 1 | Read is a secure access |
| rd_data | output | 32 | Combinational read data |
| grp0_en | output | 1 | Group-0 enable |
| grp1ns_en | output | 1 | Non-secure group-1 enable |
| grp1s_en | output | 1 | Secure group-1 enable |
| sec_dis | output | 1 | Security-disable state |

## Verification
The assertions check the following on every cycle:
- The disable bit only ever rises.
- The secure group-1 enable is off whenever security is disabled.
- A non-secure write with security enabled leaves bits 0, 2 and 6 untouched.
- The non-secure read view exposes only bits 4 and 1.

Only the bench's scenarios can show the rest:
- Secure writes land with the right values, checked by sweeping data patterns through both security phases.
- Set-time clearing of bits 2 and 5 happens even when bit 2 is written as one.
- The configuration word has the correct packing and ignores writes.
- A reset ends the disabled state.

// File: rtl/banked_dist_ctrl.sv
module banked_dist_ctrl #(
  parameter int NUM_IRQ       = 256,
  parameter int SEC_SUPPORTED = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic        wr_secure,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  input  logic        rd_secure,
  output logic [31:0] rd_data,
  output logic        grp0_en,
  output logic        grp1ns_en,
  output logic        grp1s_en,
  output logic        sec_dis
);
  localparam int LINES = (NUM_IRQ - 32) / 32 - 1;
  localparam logic [31:0] CFG_WORD =
    {6'b0, 1'b1, 1'b1, 5'hF, 8'b0, 1'(SEC_SUPPORTED), 5'b0, 5'(LINES)};

  logic route_ns;
  logic ctrl_wr;
  logic [31:0] full_view, ns_view;

  assign ctrl_wr = wr_en && !wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp0_en   <= 1'b0;
      grp1ns_en <= 1'b0;
      grp1s_en  <= 1'b0;
      sec_dis   <= 1'b0;
      route_ns  <= 1'b1;
    end else if (ctrl_wr) begin
      if (sec_dis) begin
        grp0_en   <= wr_data[0];
        grp1ns_en <= wr_data[1];
      end else if (wr_secure) begin
        grp0_en   <= wr_data[0];
        grp1ns_en <= wr_data[1];
        grp1s_en  <= wr_data[2] && !wr_data[6];
        if (wr_data[6]) begin
          sec_dis  <= 1'b1;
          route_ns <= 1'b0;
        end
      end else begin
        grp1ns_en <= wr_data[1];
      end
    end
  end

  assign full_view = {25'b0, sec_dis, route_ns, 1'b1, 1'b0, grp1s_en, grp1ns_en, grp0_en};
  assign ns_view   = {27'b0, 1'b1, 1'b0, 1'b0, grp1ns_en, 1'b0};

  assign rd_data = rd_sel ? CFG_WORD :
                   (!rd_secure && !sec_dis) ? ns_view : full_view;
endmodule

// File: rtl/banked_dist_ctrl_chk.sv
module banked_dist_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic        wr_secure,
  input logic        rd_sel,
  input logic        rd_secure,
  input logic [31:0] rd_data,
  input logic        grp0_en,
  input logic        grp1ns_en,
  input logic        grp1s_en,
  input logic        sec_dis
);
  // R9
  dis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_dis |=> sec_dis);

  // R6
  dis_clears_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_dis |-> !grp1s_en);

  // R4
  ns_write_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !wr_secure && !sec_dis)
      |=> ($stable(grp0_en) && $stable(grp1s_en) && $stable(sec_dis)));

  // R5
  ns_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel && !rd_secure && !sec_dis)
      |-> (((rd_data & ~32'h0000_0012) == 32'h0) && rd_data[4] && (rd_data[1] == grp1ns_en)));

  // R2
  route_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel) |-> (rd_data[4] && !rd_data[31]));
endmodule

bind banked_dist_ctrl banked_dist_ctrl_chk chk_i (.*);

// File: tb/banked_dist_ctrl_tb_top.sv
module banked_dist_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, wr_secure = 1'b0;
  logic [31:0] wr_data = '0;
  logic rd_sel = 1'b0, rd_secure = 1'b0;
  logic [31:0] rd_data;
  logic grp0_en, grp1ns_en, grp1s_en, sec_dis;

  int checks = 0, fails = 0;
  logic m_en0, m_en1ns, m_en1s, m_ds, m_rns;

  always #10 clk = ~clk;

  banked_dist_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_secure(wr_secure), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_secure(rd_secure), .rd_data(rd_data), .grp0_en(grp0_en),
    .grp1ns_en(grp1ns_en), .grp1s_en(grp1s_en), .sec_dis(sec_dis));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] full_exp();
    return {25'b0, m_ds, m_rns, 1'b1, 1'b0, m_en1s, m_en1ns, m_en0};
  endfunction

  task automatic model_reset();
    m_en0 = 0; m_en1ns = 0; m_en1s = 0; m_ds = 0; m_rns = 1;
  endtask

  task automatic do_write(input logic sel, input logic sec, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_secure = sec; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (!sel) begin
      if (m_ds) begin m_en0 = d[0]; m_en1ns = d[1]; end
      else if (sec) begin
        m_en0 = d[0]; m_en1ns = d[1]; m_en1s = d[2] & ~d[6];
        if (d[6]) begin m_ds = 1; m_rns = 0; end
      end else m_en1ns = d[1];
    end
  endtask

  task automatic check_reads(input string req);
    rd_sel = 0; rd_secure = 1; #1;
    check({req, " secure view"}, rd_data, full_exp());
    rd_secure = 0; #1;
    check({req, " non-secure view"}, rd_data,
          m_ds ? full_exp() : {27'b0, 1'b1, 2'b0, m_en1ns, 1'b0});
    rd_sel = 1; #1;
    check({req, " config word"}, rd_data, 32'h0378_0406);
    rd_sel = 0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check_reads("R1");
    check("R1 enables", {28'b0, sec_dis, grp1s_en, grp1ns_en, grp0_en}, 32'h0);
    // R3 and R2: secure writes with noise on routing and upper bits
    for (int i = 0; i < 16; i++) begin
      do_write(0, 1, (32'(i) & 32'h7) | (i[3] ? 32'hFFFF_FF38 : 32'h8000_0000));
      check_reads("R3");
    end
    // R4: non-secure writes try every bit including disable
    for (int i = 0; i < 8; i++) begin
      do_write(0, 1, 32'h5);
      do_write(0, 0, {25'b0, 1'b1, 4'b0, 1'(i[0]), 1'b0} | (i[1] ? 32'h5 : 32'h0));
      check_reads("R4");
    end
    // R8: configuration writes ignored
    do_write(1, 1, 32'hFFFF_FFFF);
    do_write(1, 0, 32'h0);
    check_reads("R8");
    // R6: disable with bit 2 written as one
    do_write(0, 1, 32'h0000_0047);
    check_reads("R6");
    check("R6 sec_dis pin", {31'b0, sec_dis}, 32'h1);
    // R7: every access only touches bits 0 and 1
    for (int i = 0; i < 16; i++) begin
      do_write(0, i[2], (32'(i) & 32'h3) | (i[3] ? 32'hFFFF_FFFC : 32'h0));
      check_reads("R7");
    end
    // R9: reset leaves disabled state
    @(negedge clk);
    rst_n = 0;
    model_reset();
    @(negedge clk);
    rst_n = 1;
    #1;
    check_reads("R9");
    do_write(0, 0, 32'h2);
    check_reads("R9 banking restored");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule